// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave side of a byte-wide serial memory that sits on a four-wire SPI bus. A controller pulls chip select low and sends an 8-bit instruction. Depending on the instruction, a 16-bit address and data bytes follow. The block decodes the instruction and keeps a write enable latch and a status byte. It checks every write against a block-protection matrix built from the latch, a protect-enable status bit and the write-protect pin. Read data and status go back on SO. A 2K x 8 register array stands in for the nonvolatile cells. A cycle counter models the internal write time, during which the write-in-progress flag is high.

All bus pins are sampled with the system clock `clk`. Chip select, SCK and SI each pass through a two-stage synchronizer, and SCK edges are found by comparing the synchronized samples. Data bytes of a WRITE are collected in a 16-byte page buffer. When chip select rises on a byte boundary, the write cycle starts and the buffer drains into the array one byte per clock, skipping protected bytes. Status bits loaded by a status write take effect when that write cycle ends.

The control state machine has these states. S_IDLE: deselected. S_CMD: receiving the instruction. S_ADDR_HI and S_ADDR_LO: receiving the address. S_READ: streaming array bytes. S_WRITE: filling the page buffer. S_STAT_OUT: streaming the status byte. S_STAT_IN: taking a status write byte. S_SKIP: discarding the rest of the frame. The transitions are as follows. A falling chip select moves any state to S_CMD, and a rising chip select moves any state to S_IDLE. In S_CMD, the instruction byte selects the next state. Read-status goes to S_STAT_OUT. Read and write go to S_ADDR_HI. Write-status goes to S_STAT_IN. Everything else goes to S_SKIP, and so does any instruction other than read-status received while a write cycle runs. S_ADDR_HI moves to S_ADDR_LO after one byte. S_ADDR_LO then moves to S_READ or S_WRITE.

Top module: `spimem_ctrl`

## Requirements
- R1: All instruction, address and data bytes travel most significant bit first. SI is sampled on rising SCK and SO changes after falling SCK, with the first output bit appearing after the falling edge that follows the last input bit. SO is high-impedance while chip select is high.
- R2: Opcode 8'h06 sets the write enable latch (status bit 1). Opcode 8'h04 clears both the latch and the flag bit (status bit 6). Opcode 8'h00 sets the flag bit.
- R3: Opcode 8'h05 returns the status byte, repeated for as long as chip select stays low. Bit 7 is protect-enable, bit 6 the flag, bits 5:4 the watchdog field, bits 3:2 the block field, bit 1 the latch and bit 0 write-in-progress. It reads 8'h00 after reset and also works during a write cycle.
- R4: Opcode 8'h03 followed by a 16-bit address (low 11 bits used) streams array bytes from that address. The address increments after each byte and wraps from 11'h7FF to 11'h000.
- R5: Opcode 8'h02 followed by a 16-bit address takes data bytes. Each byte lands at the next location within the same 16-byte page, and the low 4 address bits wrap inside the page.
- R6: A write cycle starts only when chip select rises after a whole number of data bytes, with at least one data byte and the latch set. A frame cut off mid-byte writes nothing and leaves the latch unchanged.
- R7: Write-in-progress stays high for WR_CYCLES clocks after the cycle starts. The latch clears when the cycle ends.
- R8: While write-in-progress is high, every instruction other than 8'h05 is ignored.
- R9: With the latch clear, neither the array nor the status byte can be written.
- R10: The block field selects the protected region: 2'b00 none, 2'b01 addresses 11'h600 to 11'h7FF, 2'b10 11'h400 to 11'h7FF, 2'b11 the whole array. Protected bytes are never written, while unprotected bytes of the same write are.
- R11: Opcode 8'h01 loads bits 7 and 5:2 from its first data byte, and the new values appear when its write cycle ends. It needs the latch set and either protect-enable 0 or the write-protect pin high. Otherwise it is ignored and the latch stays set.
- R12: SCK may stop for any time in either level without losing the transfer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_wp_n | input | 1 | Write-protect pin, active low |
| spi_so | output | 1 | Serial data out, high-impedance while deselected |

## Verification
The assertions take for granted a bus that is slow next to `clk`. Each SCK level must last at least five system clocks. SI and the write-protect pin must stay steady around the sampling edges, and chip select must move only while SCK is low. Under these conditions, a write cycle can only begin after chip select has been seen high on the pin. The bench always holds each SCK phase for at least five clocks and adds random stretches. It toggles chip select only after a falling SCK edge has had time to settle, and it changes the write-protect pin only between frames.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam logic [7:0] OP_SETFLAG  = 8'h00;
    localparam logic [7:0] OP_WRSTAT   = 8'h01;
    localparam logic [7:0] OP_WRITE    = 8'h02;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_CLRLATCH = 8'h04;
    localparam logic [7:0] OP_RDSTAT   = 8'h05;
    localparam logic [7:0] OP_SETLATCH = 8'h06;

    // Status bits 7 and 5:2 carry over between write cycles.
    localparam logic [7:0] STAT_WMASK  = 8'hBC;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADDR_HI,
        S_ADDR_LO,
        S_READ,
        S_WRITE,
        S_STAT_OUT,
        S_STAT_IN,
        S_SKIP
    } state_t;

    typedef struct packed {
        logic       wpen;
        logic       flag;
        logic [1:0] wdog;
        logic [1:0] blk;
    } stat_nv_t;

endpackage

// File: rtl/spimem_shifter.sv
module spimem_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sck,
    input  logic         si,
    output logic         sel,
    output logic         cs_fall,
    output logic         cs_rise,
    output logic         sck_fall,
    output logic         byte_done,
    output logic [W-1:0] byte_val,
    output logic         aligned
);
    localparam int CNT_W = $clog2(W);

    logic [2:0]       cs_q;
    logic [2:0]       sck_q;
    logic [1:0]       si_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-2:0]     shreg;
    logic             sck_rise;

    // two synchronizer stages plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 3'b111;
            sck_q <= 3'b000;
            si_q  <= 2'b00;
        end else begin
            cs_q  <= {cs_q[1:0], cs_n};
            sck_q <= {sck_q[1:0], sck};
            si_q  <= {si_q[0], si};
        end
    end

    assign sel      = !cs_q[1];
    assign cs_fall  = cs_q[2] && !cs_q[1];
    assign cs_rise  = !cs_q[2] && cs_q[1];
    assign sck_rise = sel && !sck_q[2] && sck_q[1];
    assign sck_fall = sel && sck_q[2] && !sck_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!sel) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[W-3:0], si_q[1]};
        end
    end

    assign byte_done = sck_rise && (bit_cnt == CNT_W'(W - 1));
    assign byte_val  = {shreg, si_q[1]};
    assign aligned   = (bit_cnt == '0);

endmodule

// File: rtl/spimem_protect.sv
module spimem_protect #(
    parameter int ADDR_W = 11
) (
    input  logic              wel,
    input  logic              wpen,
    input  logic              wp_n,
    input  logic [1:0]        blk,
    input  logic [ADDR_W-1:0] addr,
    output logic              stat_ok,
    output logic              blk_hit,
    output logic              arr_ok
);
    always_comb begin
        unique case (blk)
            2'b00:   blk_hit = 1'b0;
            2'b01:   blk_hit = &addr[ADDR_W-1 -: 2];
            2'b10:   blk_hit = addr[ADDR_W-1];
            default: blk_hit = 1'b1;
        endcase
        stat_ok = wel && (!wpen || wp_n);
        arr_ok  = wel && !blk_hit;
    end

endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
    import spimem_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    input  logic spi_wp_n,
    output logic spi_so
);
    localparam int PAGE   = 1 << PAGE_W;
    localparam int CYC_W  = $clog2(WR_CYCLES + 1);
    localparam int BASE_W = ADDR_W - PAGE_W;

    state_t state, state_nxt;

    logic              sel, cs_fall, cs_rise, sck_fall, byte_done, aligned;
    logic [7:0]        byte_val;
    logic [15:0]       addr_full;
    logic [7:0]        addr_hi;
    logic              is_write;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        out_sr;
    logic [2:0]        out_cnt;
    logic              so_q;

    logic [7:0]        wbuf [PAGE];
    logic [PAGE-1:0]   wvalid;
    logic [BASE_W-1:0] wbase;
    logic [PAGE_W-1:0] wr_idx;

    stat_nv_t          stat_nv;
    logic [7:0]        stat_pend;
    logic              stat_seen;
    logic              wel;
    logic              busy;
    logic              arr_cycle;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [PAGE_W:0]   commit_idx;

    logic [ADDR_W-1:0] commit_addr;
    logic              stat_ok, blk_hit, arr_ok;
    logic              mem_we;
    logic [7:0]        mem_rdata;
    logic [7:0]        status_byte;
    logic              start_wr, start_stat;
    logic [7:0]        load_byte;

    spimem_shifter #(.W(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .si        (spi_si),
        .sel       (sel),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sck_fall  (sck_fall),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .aligned   (aligned)
    );

    assign commit_addr = {wbase, commit_idx[PAGE_W-1:0]};

    spimem_protect #(.ADDR_W(ADDR_W)) u_prot (
        .wel     (wel),
        .wpen    (stat_nv.wpen),
        .wp_n    (spi_wp_n),
        .blk     (stat_nv.blk),
        .addr    (commit_addr),
        .stat_ok (stat_ok),
        .blk_hit (blk_hit),
        .arr_ok  (arr_ok)
    );

    assign mem_we = busy && arr_cycle && !commit_idx[PAGE_W]
                 && wvalid[commit_idx[PAGE_W-1:0]] && arr_ok;

    spimem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (commit_addr),
        .wdata (wbuf[commit_idx[PAGE_W-1:0]]),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    assign addr_full   = {addr_hi, byte_val};
    assign status_byte = {stat_nv.wpen, stat_nv.flag, stat_nv.wdog, stat_nv.blk, wel, busy};
    assign load_byte   = (state == S_READ) ? mem_rdata : status_byte;

    assign start_wr   = cs_rise && (state == S_WRITE) && aligned && (|wvalid)
                     && wel && !busy;
    assign start_stat = cs_rise && (state == S_STAT_IN) && aligned && stat_seen
                     && stat_ok && !busy;

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (cs_rise) begin
            state_nxt = S_IDLE;
        end else if (cs_fall) begin
            state_nxt = S_CMD;
        end else if (byte_done) begin
            unique case (state)
                S_CMD: begin
                    if (busy && byte_val != OP_RDSTAT) begin
                        state_nxt = S_SKIP;
                    end else begin
                        case (byte_val)
                            OP_RDSTAT: state_nxt = S_STAT_OUT;
                            OP_READ,
                            OP_WRITE:  state_nxt = S_ADDR_HI;
                            OP_WRSTAT: state_nxt = S_STAT_IN;
                            default:   state_nxt = S_SKIP;
                        endcase
                    end
                end
                S_ADDR_HI: state_nxt = S_ADDR_LO;
                S_ADDR_LO: state_nxt = is_write ? S_WRITE : S_READ;
                default:   state_nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // page buffer storage (no reset: guarded by wvalid)
    always_ff @(posedge clk) begin
        if (byte_done && state == S_WRITE) wbuf[wr_idx] <= byte_val;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi    <= '0;
            is_write   <= 1'b0;
            ptr        <= '0;
            out_sr     <= '0;
            out_cnt    <= '0;
            so_q       <= 1'b0;
            wvalid     <= '0;
            wbase      <= '0;
            wr_idx     <= '0;
            stat_nv    <= '0;
            stat_pend  <= '0;
            stat_seen  <= 1'b0;
            wel        <= 1'b0;
            busy       <= 1'b0;
            arr_cycle  <= 1'b0;
            cyc_cnt    <= '0;
            commit_idx <= '0;
        end else begin
            // internal write cycle
            if (busy) begin
                if (!commit_idx[PAGE_W]) commit_idx <= commit_idx + 1'b1;
                if (cyc_cnt == '0) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                    if (!arr_cycle) begin
                        stat_nv.wpen <= stat_pend[7];
                        stat_nv.wdog <= stat_pend[5:4];
                        stat_nv.blk  <= stat_pend[3:2];
                    end
                end else begin
                    cyc_cnt <= cyc_cnt - 1'b1;
                end
            end else if (start_wr || start_stat) begin
                busy       <= 1'b1;
                arr_cycle  <= start_wr;
                cyc_cnt    <= CYC_W'(WR_CYCLES - 1);
                commit_idx <= '0;
            end

            if (cs_fall) begin
                out_cnt <= '0;
                so_q    <= 1'b0;
            end

            if (byte_done) begin
                unique case (state)
                    S_CMD: begin
                        is_write  <= (byte_val == OP_WRITE);
                        stat_seen <= 1'b0;
                        if (!busy) begin
                            if (byte_val == OP_SETLATCH) wel <= 1'b1;
                            if (byte_val == OP_CLRLATCH) begin
                                wel          <= 1'b0;
                                stat_nv.flag <= 1'b0;
                            end
                            if (byte_val == OP_SETFLAG) stat_nv.flag <= 1'b1;
                        end
                    end
                    S_ADDR_HI: addr_hi <= byte_val;
                    S_ADDR_LO: begin
                        ptr <= addr_full[ADDR_W-1:0];
                        if (is_write) begin
                            wbase  <= addr_full[ADDR_W-1:PAGE_W];
                            wr_idx <= addr_full[PAGE_W-1:0];
                            wvalid <= '0;
                        end
                    end
                    S_WRITE: begin
                        wvalid[wr_idx] <= 1'b1;
                        wr_idx         <= wr_idx + 1'b1;
                    end
                    S_STAT_IN: begin
                        if (!stat_seen) begin
                            stat_pend <= byte_val & STAT_WMASK;
                            stat_seen <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (sck_fall && (state == S_READ || state == S_STAT_OUT)) begin
                if (out_cnt == '0) begin
                    so_q    <= load_byte[7];
                    out_sr  <= {load_byte[6:0], 1'b0};
                    out_cnt <= 3'd7;
                    if (state == S_READ) ptr <= ptr + 1'b1;
                end else begin
                    so_q    <= out_sr[7];
                    out_sr  <= {out_sr[6:0], 1'b0};
                    out_cnt <= out_cnt - 1'b1;
                end
            end
        end
    end

    assign spi_so = spi_cs_n ? 1'bz : so_q;

endmodule

// File: rtl/spimem_ctrl_checker.sv
module spimem_ctrl_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              busy,
    input logic              wel,
    input logic [1:0]        blk,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    logic in_region;
    always_comb begin
        in_region = (blk == 2'b11)
                 || (blk == 2'b10 && mem_waddr[ADDR_W-1])
                 || (blk == 2'b01 && mem_waddr[ADDR_W-1] && mem_waddr[ADDR_W-2]);
    end

    assert_latch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_cycle_needs_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    assert_cycle_after_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> spi_cs_n);

    assert_array_write_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy && wel);

    assert_no_protected_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_region);

    assert_block_field_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk) |-> $fell(busy));

endmodule

bind spimem_ctrl spimem_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy),
    .wel       (wel),
    .blk       (stat_nv.blk),
    .mem_we    (mem_we),
    .mem_waddr (commit_addr)
);

// File: tb/spimem_ctrl_test.sv
`timescale 1ns/100ps
module spimem_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    wire  so;

    always #2.5 clk = ~clk;

    spimem_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sck  (sck),
        .spi_si   (si),
        .spi_wp_n (wp_n),
        .spi_so   (so)
    );

    int n_run  = 0;
    int n_fail = 0;
    int gap_max = 0;
    bit done = 0;

    logic [7:0] mem_m [2048];
    logic       m_wel, m_flag;
    logic [7:0] m_nv;
    logic [7:0] wdat [16];
    logic [7:0] rdat [16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {m_nv[7], m_flag, m_nv[5:2], m_wel, 1'b0};
    endfunction

    function automatic bit prot(input logic [10:0] a);
        case (m_nv[3:2])
            2'b00:   return 1'b0;
            2'b01:   return a >= 11'h600;
            2'b10:   return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            repeat (6 + $urandom_range(gap_max, 0)) @(negedge clk);
            rx[i] = so;
            sck = 1'b1;
            repeat (5 + $urandom_range(gap_max, 0)) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        xfer(tx, rx);
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic simple(input logic [7:0] op);
        cs_low(); send(op); cs_high();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r2;
        cs_low(); send(8'h05); xfer(8'h00, s); xfer(8'h00, r2); cs_high();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 30 && s[0]; k++) rdsr(s);
        chk("R7 write-in-progress clears", {31'd0, s[0]}, 32'd0);
        chk("R7 latch cleared after cycle", {31'd0, s[1]}, 32'd0);
        m_wel = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input int n);
        bit go;
        cs_low(); send(8'h02); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) send(wdat[i]);
        cs_high();
        go = m_wel && n > 0;
        if (go) begin
            for (int i = 0; i < n; i++) begin
                logic [10:0] pa;
                pa = {a[10:4], 4'(a[3:0] + i)};
                if (!prot(pa)) mem_m[pa] = wdat[i];
            end
            wait_idle();
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        cs_low(); send(8'h03); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) xfer(8'hFF, rdat[i]);
        cs_high();
    endtask

    task automatic verify_read(input string req, input logic [15:0] a, input int n);
        int bad;
        bad = 0;
        do_read(a, n);
        for (int i = 0; i < n; i++) begin
            logic [10:0] pa;
            pa = 11'(a[10:0] + i);
            if (rdat[i] !== mem_m[pa]) begin
                bad++;
                $display("FAIL %s: addr %0h actual %0h expected %0h", req, pa, rdat[i], mem_m[pa]);
            end
        end
        n_run++;
        if (bad != 0) n_fail++;
    endtask

    task automatic do_wrsr(input logic [7:0] d);
        bit go;
        cs_low(); send(8'h01); send(d); cs_high();
        go = m_wel && (!m_nv[7] || wp_n);
        if (go) begin
            m_nv = d & 8'hBC;
            wait_idle();
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s, s2;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) mem_m[i] = 8'h00;
        m_wel = 0; m_flag = 0; m_nv = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: reset value and repetition
        cs_low(); send(8'h05); xfer(8'h00, s); xfer(8'h00, s2); cs_high();
        chk("R3 status after reset", s, 8'h00);
        chk("R3 status repeats", s2, 8'h00);

        // R2: latch and flag opcodes
        simple(8'h06); m_wel = 1; rdsr(s);
        chk("R2 set latch", s, exp_stat());
        simple(8'h00); m_flag = 1; rdsr(s);
        chk("R2 set flag", s, exp_stat());
        simple(8'h04); m_wel = 0; m_flag = 0; rdsr(s);
        chk("R2 clear latch and flag", s, exp_stat());
        simple(8'h07); rdsr(s);
        chk("R2 unknown opcode ignored", s, exp_stat());

        // R9: write with latch clear does nothing
        for (int i = 0; i < 4; i++) wdat[i] = 8'hA0 + 8'(i);
        do_write(16'h0040, 4); rdsr(s);
        chk("R9 no cycle without latch", s, exp_stat());
        verify_read("R9 array untouched", 16'h0040, 4);

        // R5/R7/R3: committed write, status during cycle
        simple(8'h06); m_wel = 1;
        cs_low(); send(8'h02); send(8'h00); send(8'h40);
        for (int i = 0; i < 4; i++) send(wdat[i]);
        cs_high();
        rdsr(s);
        chk("R3 status during write cycle", s, 8'h03);
        for (int i = 0; i < 4; i++) mem_m[11'h040 + i] = wdat[i];
        // R8: instructions ignored during the cycle
        simple(8'h00);
        cs_low(); send(8'h02); send(8'h00); send(8'h80); send(8'h55); cs_high();
        wait_idle();
        rdsr(s);
        chk("R8 flag not set during cycle", s, exp_stat());
        verify_read("R1 R5 write then read", 16'h0040, 4);
        verify_read("R8 write during cycle ignored", 16'h0080, 1);

        // R5: wrap inside page
        simple(8'h06); m_wel = 1;
        wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
        do_write(16'h00FE, 3);
        verify_read("R5 page wrap 0FE", 16'h00FE, 2);
        verify_read("R5 page wrap 0F0", 16'h00F0, 1);

        // R4: address wrap at top, upper address bits ignored
        simple(8'h06); m_wel = 1;
        wdat[0] = 8'h7E; wdat[1] = 8'h7F;
        do_write(16'h07FE, 2);
        simple(8'h06); m_wel = 1;
        wdat[0] = 8'hC0; wdat[1] = 8'hC1;
        do_write(16'hF800, 2);
        verify_read("R4 read wraps past top", 16'h07FE, 4);
        verify_read("R4 upper address bits ignored", 16'hA7FE, 3);

        // R6: frame cut mid-byte
        simple(8'h06); m_wel = 1;
        cs_low(); send(8'h02); send(8'h02); send(8'h00); send(8'h99);
        si = 1'b1;
        for (int b = 0; b < 3; b++) begin
            repeat (6) @(negedge clk); sck = 1'b1; repeat (5) @(negedge clk); sck = 1'b0;
        end
        cs_high();
        rdsr(s);
        chk("R6 no cycle on partial byte", s, exp_stat());
        verify_read("R6 array untouched", 16'h0200, 1);
        cs_low(); send(8'h02); send(8'h02); send(8'h00); cs_high();
        rdsr(s);
        chk("R6 no cycle without data byte", s, exp_stat());

        // R11: status write, then protect-enable with pin low
        do_wrsr(8'hA7);
        rdsr(s);
        chk("R11 status write masked", s, 8'hA4);
        wp_n = 1'b0;
        simple(8'h06); m_wel = 1;
        do_wrsr(8'h00);
        rdsr(s);
        chk("R11 status write blocked by pin", s, exp_stat());
        // R10: block field 01, unprotected write still allowed
        for (int i = 0; i < 4; i++) wdat[i] = 8'h50 + 8'(i);
        do_write(16'h05FC, 4);
        verify_read("R10 below quarter written", 16'h05FC, 4);
        simple(8'h06); m_wel = 1;
        do_write(16'h0600, 2);
        verify_read("R10 upper quarter protected", 16'h0600, 2);
        wp_n = 1'b1;

        // R10: block field 10
        simple(8'h06); m_wel = 1;
        do_wrsr(8'h08);
        rdsr(s);
        chk("R11 status write with pin high", s, 8'h08);
        simple(8'h06); m_wel = 1;
        for (int i = 0; i < 4; i++) wdat[i] = 8'h60 + 8'(i);
        do_write(16'h03FC, 4);
        simple(8'h06); m_wel = 1;
        do_write(16'h0400, 4);
        verify_read("R10 half boundary", 16'h03FC, 8);

        // R10: whole array protected
        simple(8'h06); m_wel = 1;
        do_wrsr(8'h0C);
        simple(8'h06); m_wel = 1;
        do_write(16'h0010, 2);
        verify_read("R10 whole array protected", 16'h0010, 2);
        simple(8'h06); m_wel = 1;
        do_wrsr(8'h00);

        // R12: long random SCK stalls
        gap_max = 40;
        simple(8'h06); m_wel = 1;
        for (int i = 0; i < 3; i++) wdat[i] = 8'($urandom);
        do_write(16'h0123, 3);
        verify_read("R12 paused clock", 16'h0123, 3);
        gap_max = 3;

        // random mix
        for (int t = 0; t < 16; t++) begin
            logic [15:0] a;
            int n;
            a = 16'($urandom);
            n = $urandom_range(6, 1);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            if ($urandom_range(3, 0) != 0) begin
                simple(8'h06); m_wel = 1;
            end
            do_write(a, n);
            verify_read("R4 R5 random write/read", {5'd0, a[10:4], 4'd0}, 16);
        end
        rdsr(s);
        chk("R3 final status", s, exp_stat());

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule